// File: doc/BRIEF.md
# Quadrature Input Decoder with Index

This block is the input stage of one encoder counter channel. It brings three asynchronous pins (the two encoder phases and an index mark) into the clock domain. From them it produces single-cycle count pulses with a direction, and single-cycle preset-load requests for the counter that follows it. The counter and the host bus are not part of this block.

The host configures the block with byte-wide commands. A mode command sets the count resolution: plain clock/direction, or quadrature at one, two or four counts per encoder cycle. An I/O command gates the encoder phases and the preset-on-index request. An index command sets the index polarity and whether the index must line up with a particular phase state. The block also outputs the synchronised index level and a sticky flag that reports an illegal phase transition.

Top module: `qdi_frontend`

## Requirements
- R1: After reset, the mode is plain with the encoder phases disabled. Preset-on-index is enabled, the index is asynchronous with negative polarity, and `noise_err` and `cnt_up` are 0. No count or preset-load pulse is issued until an input or command calls for one.
- R2: A command byte takes effect from the cycle after `cmd_valid`. Bits [7:5] select its class. Class 3'b001 is a mode command: bits [4:3] are the quadrature field, 0 = plain, 1 = x1, 2 = x2, 3 = x4. Class 3'b010 is an I/O command: bit 0 enables the phases and bit 1 disables preset-on-index. Class 3'b011 is an index command: bit 0 requests synchronous index and bit 1 selects positive polarity. The byte 8'h06 clears the noise flag. Any other byte has no effect.
- R3: While the phase enable is 0, no count pulse is issued.
- R4: In plain mode, each rising edge of A gives one count. The direction is up when B is 1 and down when B is 0. Changes of B alone give no count.
- R5: In quadrature mode, one full encoder cycle gives 1 count (x1, on rising edges of A), 2 counts (x2, on both edges of A) or 4 counts (x4, on every phase edge). The direction is up when A leads B, that is, for the order AB = 00, 10, 11, 01.
- R6: `cnt_up` gives the direction of the most recent count and holds it between counts.
- R7: In quadrature mode with the phases enabled, a sample in which A and B both change gives no count and sets `noise_err`. The flag stays set until the clear command. Plain mode never sets it.
- R8: With preset-on-index enabled and asynchronous index, each transition of the index into its active level (low for negative polarity, high for positive) gives exactly one `preset_load` pulse.
- R9: When I/O bit 1 is 1, the index never gives a `preset_load` pulse.
- R10: In synchronous index mode, the index event is the moment when the index is active and A and B are both low at once. Synchronous index is refused while the mode is plain, and changing the mode to plain turns it off.
- R11: `idx_level` follows the synchronised raw index pin, whatever the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Index pin (asynchronous) |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Command byte |
| cnt_en | output | 1 | One-cycle count pulse |
| cnt_up | output | 1 | Direction of the latest count, 1 = up |
| preset_load | output | 1 | One-cycle request to load the preset |
| idx_level | output | 1 | Synchronised index level |
| noise_err | output | 1 | Sticky illegal-transition flag |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default of 2. The scoreboard pairs each expected count or load with the next pulse seen, with no fixed cycle offset, so the extra stage does not change the checks. At the same time it shows that no decode path assumes a fixed synchroniser depth. With this depth the bench can walk the full encoder cycle in both directions in every resolution, and it can place simultaneous phase changes and index edges while the phases sit at 00 or away from 00.

// File: rtl/qdi_pkg.sv
package qdi_pkg;

    typedef enum logic [1:0] {
        QM_PLAIN = 2'd0,
        QM_X1    = 2'd1,
        QM_X2    = 2'd2,
        QM_X4    = 2'd3
    } quad_mode_e;

    typedef struct packed {
        quad_mode_e quad;
        logic       ab_en;
        logic       preset_off;
        logic       idx_sync;
        logic       idx_pos;
    } chan_cfg_t;

    typedef struct packed {
        logic pa;
        logic pb;
        logic en;
        logic up;
        logic noise;
    } quad_state_t;

    typedef struct packed {
        logic qual;
        logic load;
    } idx_state_t;

    localparam int          CMD_W       = 8;
    localparam logic [2:0]  CLS_MODE    = 3'b001;
    localparam logic [2:0]  CLS_IO      = 3'b010;
    localparam logic [2:0]  CLS_IDX     = 3'b011;
    localparam logic [CMD_W-1:0] CMD_ERR_CLR = 8'h06;

    localparam chan_cfg_t CFG_RESET = '{
        quad:       QM_PLAIN,
        ab_en:      1'b0,
        preset_off: 1'b0,
        idx_sync:   1'b0,
        idx_pos:    1'b0
    };

endpackage

// File: rtl/qdi_sync.sv
module qdi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/qdi_quad.sv
module qdi_quad
    import qdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a,
    input  logic       b,
    input  quad_mode_e quad,
    input  logic       ab_en,
    input  logic       err_clr,
    output logic       cnt_en,
    output logic       cnt_up,
    output logic       noise_err
);
    quad_state_t st_d, st_q;
    logic a_chg, b_chg, fwd, hit, dir, bad;

    always_comb begin
        a_chg = a ^ st_q.pa;
        b_chg = b ^ st_q.pb;
        fwd   = a_chg ? (a ^ b) : ~(a ^ b);
        hit   = 1'b0;
        dir   = fwd;
        unique case (quad)
            QM_PLAIN: begin
                hit = a & ~st_q.pa;
                dir = b;
            end
            QM_X1:   hit = a & ~st_q.pa & ~b_chg;
            QM_X2:   hit = a_chg & ~b_chg;
            QM_X4:   hit = a_chg ^ b_chg;
            default: hit = 1'b0;
        endcase
        bad = (quad != QM_PLAIN) & a_chg & b_chg;

        st_d    = st_q;
        st_d.pa = a;
        st_d.pb = b;
        st_d.en = 1'b0;
        if (err_clr) st_d.noise = 1'b0;
        if (ab_en) begin
            if (hit) begin
                st_d.en = 1'b1;
                st_d.up = dir;
            end
            if (bad) st_d.noise = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_en    = st_q.en;
    assign cnt_up    = st_q.up;
    assign noise_err = st_q.noise;

    AST_NO_COUNT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_en |=> !cnt_en); // R3
    AST_NOISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_err && !err_clr) |=> noise_err); // R7
    AST_PLAIN_NO_NOISE: assert property (@(posedge clk) disable iff (!rst_n)
        (quad == QM_PLAIN && !noise_err) |=> !noise_err); // R7
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |-> $stable(cnt_up)); // R6

endmodule

// File: rtl/qdi_index.sv
module qdi_index
    import qdi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idx,
    input  logic a,
    input  logic b,
    input  logic idx_pos,
    input  logic idx_sync,
    input  logic preset_off,
    output logic preset_load
);
    idx_state_t ix_d, ix_q;
    logic active;

    always_comb begin
        active    = idx_pos ? idx : ~idx;
        ix_d.qual = active & (~idx_sync | (~a & ~b));
        ix_d.load = ix_d.qual & ~ix_q.qual & ~preset_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ix_q <= '{qual: 1'b1, load: 1'b0};
        else        ix_q <= ix_d;
    end

    assign preset_load = ix_q.load;

    AST_PRESET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        preset_off |=> !preset_load); // R9
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        preset_load |=> !preset_load); // R8

endmodule

// File: rtl/qdi_frontend.sv
module qdi_frontend
    import qdi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_data,
    output logic             cnt_en,
    output logic             cnt_up,
    output logic             preset_load,
    output logic             idx_level,
    output logic             noise_err
);
    localparam int PIN_W = 3;

    chan_cfg_t      cfg_d, cfg_q;
    logic [2:0]     cls;
    logic           err_clr;
    logic [PIN_W-1:0] pins_s;

    always_comb begin
        cls     = cmd_data[7:5];
        err_clr = cmd_valid && (cmd_data == CMD_ERR_CLR);
        cfg_d   = cfg_q;
        if (cmd_valid) begin
            unique case (cls)
                CLS_MODE: begin
                    cfg_d.quad = quad_mode_e'(cmd_data[4:3]);
                    if (cmd_data[4:3] == 2'd0) cfg_d.idx_sync = 1'b0;
                end
                CLS_IO: begin
                    cfg_d.ab_en      = cmd_data[0];
                    cfg_d.preset_off = cmd_data[1];
                end
                CLS_IDX: begin
                    cfg_d.idx_pos  = cmd_data[1];
                    cfg_d.idx_sync = cmd_data[0] & (cfg_q.quad != QM_PLAIN);
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    qdi_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({enc_idx, enc_b, enc_a}),
        .dout (pins_s)
    );

    qdi_quad u_quad (
        .clk      (clk),
        .rst_n    (rst_n),
        .a        (pins_s[0]),
        .b        (pins_s[1]),
        .quad     (cfg_q.quad),
        .ab_en    (cfg_q.ab_en),
        .err_clr  (err_clr),
        .cnt_en   (cnt_en),
        .cnt_up   (cnt_up),
        .noise_err(noise_err)
    );

    qdi_index u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (pins_s[2]),
        .a          (pins_s[0]),
        .b          (pins_s[1]),
        .idx_pos    (cfg_q.idx_pos),
        .idx_sync   (cfg_q.idx_sync),
        .preset_off (cfg_q.preset_off),
        .preset_load(preset_load)
    );

    assign idx_level = pins_s[2];

    AST_SYNC_NEEDS_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.idx_sync |-> (cfg_q.quad != QM_PLAIN)); // R10
    AST_IO_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cls == CLS_IO) |=> (cfg_q.ab_en == $past(cmd_data[0]))); // R2

endmodule

// File: tb/qdi_frontend_test.sv
module qdi_frontend_test;
    import qdi_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, enc_a, enc_b, enc_idx, cmd_valid;
    logic [7:0] cmd_data;
    logic       cnt_en, cnt_up, preset_load, idx_level, noise_err;

    int    compared   = 0;
    int    mismatched = 0;
    bit    exp_dir[$];
    int    exp_loads  = 0;
    string cur_tag    = "R1";

    qdi_frontend #(.SYNC_STAGES(3)) uut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .preset_load(preset_load), .idx_level(idx_level), .noise_err(noise_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as pulses appear
    always @(negedge clk) begin : monitor
        bit e;
        if (rst_n) begin
            if (cnt_en) begin
                if (exp_dir.size() == 0) check(1'b0, {cur_tag, " spurious count"}, 1, 0);
                else begin
                    e = exp_dir.pop_front();
                    check(cnt_up == e, {cur_tag, " count direction"}, int'(cnt_up), int'(e));
                end
            end
            if (preset_load) begin
                if (exp_loads == 0) check(1'b0, {cur_tag, " spurious preset load"}, 1, 0);
                else begin
                    exp_loads--;
                    check(1'b1, {cur_tag, " preset load"}, 1, 1);
                end
            end
        end
    end

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic step(input bit na, input bit nb, input bit cnt, input bit dir);
        if (cnt) exp_dir.push_back(dir);
        @(negedge clk);
        enc_a = na;
        enc_b = nb;
        settle();
    endtask

    task automatic set_idx(input bit v, input bit load);
        if (load) exp_loads++;
        @(negedge clk);
        enc_idx = v;
        settle();
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_data  = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        check(exp_dir.size() == 0 && exp_loads == 0, {tag, " pending items"},
              exp_dir.size() + exp_loads, 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0; enc_idx = 1'b1;
        cmd_valid = 1'b0; cmd_data = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state
        cur_tag = "R1";
        check(cnt_en == 1'b0, "R1 cnt_en", int'(cnt_en), 0);
        check(preset_load == 1'b0, "R1 preset_load", int'(preset_load), 0);
        check(noise_err == 1'b0, "R1 noise_err", int'(noise_err), 0);
        check(cnt_up == 1'b0, "R1 cnt_up", int'(cnt_up), 0);
        check(idx_level == 1'b1, "R11 idx_level high", int'(idx_level), 1);
        // R1 / R3: phases disabled after reset
        step(1, 0, 0, 0); step(1, 1, 0, 0); step(0, 1, 0, 0); step(0, 0, 0, 0);
        drain("R3 reset disabled");
        // R1 / R8: default negative asynchronous preset-on-index
        cur_tag = "R8";
        set_idx(1'b0, 1'b1);
        check(idx_level == 1'b0, "R11 idx_level low", int'(idx_level), 0);
        set_idx(1'b1, 1'b0);
        drain("R8 negative");

        // R4 plain mode
        cur_tag = "R4";
        send(8'h41);
        step(0, 1, 0, 0); step(1, 1, 1, 1); step(0, 1, 0, 0);
        step(0, 0, 0, 0); step(1, 0, 1, 0); step(0, 0, 0, 0);
        step(1, 1, 1, 1);
        check(noise_err == 1'b0, "R7 plain no noise", int'(noise_err), 0);
        step(0, 0, 0, 0);
        drain("R4 plain");

        // R5 x1
        cur_tag = "R5 x1";
        send(8'h28);
        step(1, 0, 1, 1); step(1, 1, 0, 0); step(0, 1, 0, 0); step(0, 0, 0, 0);
        step(0, 1, 0, 0); step(1, 1, 1, 0); step(1, 0, 0, 0); step(0, 0, 0, 0);
        drain("R5 x1");
        // R5 x2
        cur_tag = "R5 x2";
        send(8'h30);
        step(1, 0, 1, 1); step(1, 1, 0, 0); step(0, 1, 1, 1); step(0, 0, 0, 0);
        step(0, 1, 0, 0); step(1, 1, 1, 0); step(1, 0, 0, 0); step(0, 0, 1, 0);
        drain("R5 x2");
        // R5 x4
        cur_tag = "R5 x4";
        send(8'h38);
        step(1, 0, 1, 1); step(1, 1, 1, 1); step(0, 1, 1, 1); step(0, 0, 1, 1);
        step(0, 1, 1, 0); step(1, 1, 1, 0); step(1, 0, 1, 0); step(0, 0, 1, 0);
        drain("R5 x4");

        // R3 disabled in quadrature
        cur_tag = "R3";
        send(8'h40);
        step(1, 0, 0, 0); step(1, 1, 0, 0); step(0, 1, 0, 0); step(0, 0, 0, 0);
        drain("R3 disabled");
        check(cnt_up == 1'b0, "R6 direction held", int'(cnt_up), 0);

        // R6 direction of latest count held
        cur_tag = "R6";
        send(8'h41);
        step(1, 0, 1, 1);
        settle();
        check(cnt_up == 1'b1, "R6 held up", int'(cnt_up), 1);

        // R7 noise flag
        cur_tag = "R7";
        step(0, 1, 0, 0);
        check(noise_err == 1'b1, "R7 noise set", int'(noise_err), 1);
        step(1, 1, 1, 0);
        check(noise_err == 1'b1, "R7 noise sticky", int'(noise_err), 1);
        send(8'h05);
        check(noise_err == 1'b1, "R2 other byte ignored", int'(noise_err), 1);
        send(8'h06);
        check(noise_err == 1'b0, "R7 noise cleared", int'(noise_err), 0);
        step(0, 1, 1, 1); step(0, 0, 1, 1);
        drain("R7 noise");

        // R9 preset disabled
        cur_tag = "R9";
        send(8'h42);
        set_idx(1'b0, 1'b0);
        set_idx(1'b1, 1'b0);
        drain("R9 preset off");
        send(8'h62);
        send(8'h40);
        // R8 positive polarity
        cur_tag = "R8";
        set_idx(1'b0, 1'b0);
        set_idx(1'b1, 1'b1);
        set_idx(1'b0, 1'b0);
        drain("R8 positive");

        // R10 synchronous index in x4
        cur_tag = "R10";
        send(8'h63);
        step(1, 0, 0, 0);
        set_idx(1'b1, 1'b0);
        exp_loads++;
        step(0, 0, 0, 0);
        set_idx(1'b0, 1'b0);
        set_idx(1'b1, 1'b1);
        set_idx(1'b0, 1'b0);
        drain("R10 synchronous");
        // R10 leaving quadrature clears synchronous index
        send(8'h20);
        step(1, 0, 0, 0);
        set_idx(1'b1, 1'b1);
        set_idx(1'b0, 1'b0);
        step(0, 0, 0, 0);
        drain("R10 cleared by plain mode");
        // R10 synchronous refused in plain mode
        send(8'h63);
        step(1, 0, 0, 0);
        set_idx(1'b1, 1'b1);
        set_idx(1'b0, 1'b0);
        step(0, 0, 0, 0);
        drain("R10 refused in plain");

        finish_run();
    end

endmodule